// File: doc/BRIEF.md
# Color-Keyed Binary Edge Extractor

This block sits in a streaming video path. It takes one RGB565 pixel per valid cycle in raster order, together with a start-of-frame and an end-of-line marker. Each pixel is keyed to one bit: foreground when its color lies inside a configured window, background otherwise. A second classifier, selected by a static input, accepts only colors below half intensity on all three channels.

The one-bit image then goes through a 2x2 neighbourhood test. The test keeps a foreground pixel only when that pixel lies on a boundary between foreground and background, and blanks the interior of solid regions. The window is formed from the pixel itself, its left neighbour and the two pixels above them. The pixels above come from a one-line bit buffer. The result leaves one cycle later as a one-bit edge stream, tagged with its row, its column and copies of the markers.

The configuration inputs are static. They are captured on the first pixel of each frame, so a frame is always keyed with one consistent set of limits.

Top module: `color_edge_extractor`

## Requirements
- R1: The pixel word carries red in bits 15..11, green in bits 10..5 and blue in bits 4..0.
- R2: With `cfg_half` = 0, a pixel is foreground exactly when red, green and blue each satisfy lower limit <= value <= upper limit for their channel (both limits inclusive).
- R3: With `cfg_half` = 1, a pixel is foreground exactly when bit 15, bit 10 and bit 4 are all clear, and the six limit inputs have no effect.
- R4: The mode and limits are taken from the ports on the valid pixel that has `in_sof` = 1, and are held for the rest of the frame. Changes on later pixels of the frame have no effect until the next start of frame.
- R5: A background pixel always produces `out_edge` = 0.
- R6: A foreground pixel produces `out_edge` = 1 exactly when at least one of its left, upper and upper-left neighbours is background. Neighbours outside the image (row 0, column 0) count as background.
- R7: `out_valid` is `in_valid` delayed by one clock. `out_edge`, `out_row`, `out_col`, `out_sof` and `out_eol` in that cycle describe the pixel accepted one clock earlier.
- R8: The pixel with `in_sof` = 1 is row 0, column 0. Each further valid pixel is at the next column. The pixel after one marked `in_eol` starts the next row at column 0. Rows and columns are 9 bits wide, which allows images up to 512x512.
- R9: Cycles with `in_valid` = 0 give `out_valid` = 0 and `out_edge` = 0, and they do not disturb the position or the neighbourhood of the following pixels.
- R10: While `rst_n` is low at a clock edge, the next output has `out_valid`, `out_edge`, `out_sof` and `out_eol` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_half | input | 1 | 1 selects the half-intensity classifier, 0 the window classifier |
| cfg_r_lo | input | 5 | Red lower limit (inclusive) |
| cfg_r_hi | input | 5 | Red upper limit (inclusive) |
| cfg_g_lo | input | 6 | Green lower limit (inclusive) |
| cfg_g_hi | input | 6 | Green upper limit (inclusive) |
| cfg_b_lo | input | 5 | Blue lower limit (inclusive) |
| cfg_b_hi | input | 5 | Blue upper limit (inclusive) |
| in_valid | input | 1 | Pixel strobe |
| in_pixel | input | 16 | RGB565 pixel |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_eol | input | 1 | Marks the last pixel of a line |
| out_valid | output | 1 | Output strobe |
| out_edge | output | 1 | Edge bit of the pixel |
| out_row | output | 9 | Row of the pixel |
| out_col | output | 9 | Column of the pixel |
| out_sof | output | 1 | Start-of-frame marker, delayed |
| out_eol | output | 1 | End-of-line marker, delayed |

## Verification
Two things happen in the same cycle on the first pixel of a frame: the configuration is captured, and that same pixel is classified with the values being captured. The bench drives new limits or a new mode together with a start-of-frame pixel. It then changes them again on the very next pixel, and later swaps them for the following frame. The software model keys every pixel with the values that were present on its frame's first pixel. An output that follows the ports mid-frame, or one that lags a frame behind, therefore differs from the model on the blob pixels whose color falls between the two settings.

// File: rtl/color_edge_pkg.sv
// Package color_edge_pkg
// Shared widths and the configuration record of the color-keyed edge extractor.
// Assumes RGB565 pixels: red in the top bits, blue in the bottom bits.
package color_edge_pkg;

    localparam int RED_W = 5;
    localparam int GRN_W = 6;
    localparam int BLU_W = 5;
    localparam int PIX_W = RED_W + GRN_W + BLU_W;

    // Keying configuration captured once per frame
    typedef struct packed {
        logic             half;
        logic [RED_W-1:0] r_lo;
        logic [RED_W-1:0] r_hi;
        logic [GRN_W-1:0] g_lo;
        logic [GRN_W-1:0] g_hi;
        logic [BLU_W-1:0] b_lo;
        logic [BLU_W-1:0] b_hi;
    } key_cfg_t;

endpackage

// File: rtl/color_key_classifier.sv
// Module color_key_classifier
// Purely combinational keying of one RGB565 pixel to one bit.
// Window mode: each channel within inclusive [lo, hi].
// Half mode: no channel has its most significant bit set.
// Assumes the configuration is already the frame-stable one.
module color_key_classifier
    import color_edge_pkg::*;
(
    input  logic [PIX_W-1:0] pixel,
    input  key_cfg_t         cfg,
    output logic             fg
);

    logic [RED_W-1:0] red;
    logic [GRN_W-1:0] grn;
    logic [BLU_W-1:0] blu;
    logic             in_window;
    logic             below_half;

    // Split the pixel word into its three channel fields
    always_comb begin
        red = pixel[PIX_W-1 -: RED_W];
        grn = pixel[BLU_W +: GRN_W];
        blu = pixel[BLU_W-1:0];
    end

    // Evaluate both tests and select by mode
    always_comb begin
        in_window  = (red >= cfg.r_lo) && (red <= cfg.r_hi) &&
                     (grn >= cfg.g_lo) && (grn <= cfg.g_hi) &&
                     (blu >= cfg.b_lo) && (blu <= cfg.b_hi);
        below_half = !(red[RED_W-1] || grn[GRN_W-1] || blu[BLU_W-1]);
        fg         = cfg.half ? below_half : in_window;
    end

endmodule

// File: rtl/raster_position_tracker.sv
// Module raster_position_tracker
// Derives the row and column of the pixel on the input from the frame and
// line markers. Assumes a start-of-frame pixel begins every frame; state
// advances only on valid cycles.
module raster_position_tracker #(
    parameter int ROW_W = 9,
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eol,
    output logic [ROW_W-1:0] cur_row,
    output logic [COL_W-1:0] cur_col,
    output logic             first_row,
    output logic             first_col
);

    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    // Position of the present pixel; a frame start forces the origin
    always_comb begin
        cur_row   = in_sof ? '0 : row_q;
        cur_col   = in_sof ? '0 : col_q;
        first_row = (cur_row == '0);
        first_col = (cur_col == '0);
    end

    // Advance to the next column, or wrap to the next row after a line end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (in_valid) begin
            if (in_eol) begin
                row_q <= cur_row + 1'b1;
                col_q <= '0;
            end else begin
                row_q <= cur_row;
                col_q <= cur_col + 1'b1;
            end
        end
    end

    // A line end must leave the next pixel at column 0
    assert_eol_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eol) |=> (col_q == '0));

endmodule

// File: rtl/edge_window_2x2.sv
// Module edge_window_2x2
// Boundary test on a 2x2 window of binary pixels: present, left, above,
// above-left. A one-line bit buffer supplies the row above. Neighbours
// outside the image read as background. The result is registered.
module edge_window_2x2 #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             fg_cur,
    input  logic [COL_W-1:0] col,
    input  logic             first_row,
    input  logic             first_col,
    output logic             edge_q
);

    localparam int LINE_LEN = 1 << COL_W;

    logic [LINE_LEN-1:0] line_bits;
    logic                left_q;
    logic                upl_q;
    logic                up;
    logic                left;
    logic                upl;
    logic                is_edge;

    // Gather the window, masking neighbours that lie outside the image
    always_comb begin
        up      = first_row ? 1'b0 : line_bits[col];
        left    = first_col ? 1'b0 : left_q;
        upl     = first_col ? 1'b0 : upl_q;
        is_edge = fg_cur && !(left && up && upl);
    end

    // Line buffer: overwrite this column with the present row's bit
    always_ff @(posedge clk) begin
        if (in_valid) begin
            line_bits[col] <= fg_cur;
        end
    end

    // Shift the window one column right and register the edge result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= 1'b0;
            upl_q  <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            edge_q <= in_valid && is_edge;
            if (in_valid) begin
                left_q <= fg_cur;
                upl_q  <= up;
            end
        end
    end

    // Background never yields an edge
    assert_bg_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fg_cur) |=> !edge_q);

    // Every foreground pixel of the top row is a boundary pixel
    assert_top_row_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && first_row && fg_cur) |=> edge_q);

endmodule

// File: rtl/color_edge_extractor.sv
// Module color_edge_extractor
// Top level: color keying of RGB565 pixels followed by the 2x2 boundary
// test, with a fixed one-cycle latency. Captures the configuration on each
// start-of-frame pixel. Assumes raster order and at most 2**COL_W columns.
module color_edge_extractor
    import color_edge_pkg::*;
#(
    parameter int ROW_W = 9,
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_half,
    input  logic [RED_W-1:0] cfg_r_lo,
    input  logic [RED_W-1:0] cfg_r_hi,
    input  logic [GRN_W-1:0] cfg_g_lo,
    input  logic [GRN_W-1:0] cfg_g_hi,
    input  logic [BLU_W-1:0] cfg_b_lo,
    input  logic [BLU_W-1:0] cfg_b_hi,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pixel,
    input  logic             in_sof,
    input  logic             in_eol,
    output logic             out_valid,
    output logic             out_edge,
    output logic [ROW_W-1:0] out_row,
    output logic [COL_W-1:0] out_col,
    output logic             out_sof,
    output logic             out_eol
);

    key_cfg_t         cfg_live;
    key_cfg_t         cfg_hold;
    key_cfg_t         cfg_eff;
    logic             frame_start;
    logic             fg;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;
    logic             first_row;
    logic             first_col;

    // Bundle the configuration ports and pick the frame-stable copy
    always_comb begin
        cfg_live    = '{half: cfg_half, r_lo: cfg_r_lo, r_hi: cfg_r_hi,
                        g_lo: cfg_g_lo, g_hi: cfg_g_hi,
                        b_lo: cfg_b_lo, b_hi: cfg_b_hi};
        frame_start = in_valid && in_sof;
        cfg_eff     = frame_start ? cfg_live : cfg_hold;
    end

    // Hold the configuration seen on the start-of-frame pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_hold <= '0;
        end else if (frame_start) begin
            cfg_hold <= cfg_live;
        end
    end

    color_key_classifier i_classifier (
        .pixel (in_pixel),
        .cfg   (cfg_eff),
        .fg    (fg)
    );

    raster_position_tracker #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) i_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eol    (in_eol),
        .cur_row   (cur_row),
        .cur_col   (cur_col),
        .first_row (first_row),
        .first_col (first_col)
    );

    edge_window_2x2 #(
        .COL_W (COL_W)
    ) i_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .fg_cur    (fg),
        .col       (cur_col),
        .first_row (first_row),
        .first_col (first_col),
        .edge_q    (out_edge)
    );

    // Register the strobe, markers and position tags alongside the edge bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
            out_row   <= '0;
            out_col   <= '0;
        end else begin
            out_valid <= in_valid;
            out_sof   <= in_valid && in_sof;
            out_eol   <= in_valid && in_eol;
            if (in_valid) begin
                out_row <= cur_row;
                out_col <= cur_col;
            end
        end
    end

    // Output strobe follows the input strobe by exactly one clock
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // Idle input cycles produce idle output cycles
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_edge));

    // A frame start appears at the origin on the output
    assert_sof_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (out_sof && out_row == '0 && out_col == '0));

    // Half mode rejects any pixel with a channel at half intensity or above
    assert_half_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_eff.half &&
         (in_pixel[PIX_W-1] || in_pixel[BLU_W+GRN_W-1] || in_pixel[BLU_W-1]))
        |=> !out_edge);

endmodule

// File: tb/test_color_edge_extractor.sv
module test_color_edge_extractor;

    localparam int NR_MAX = 16;
    localparam int NC_MAX = 512;
    localparam int R_LO = 8,  R_HI = 20;
    localparam int G_LO = 10, G_HI = 40;
    localparam int B_LO = 3,  B_HI = 25;

    // Blob shape, one 8-bit row bitmap per line; bit 7 is column 0
    localparam logic [7:0] BLOB [8] = '{
        8'b00000000, 8'b00111000, 8'b01111100, 8'b01111110,
        8'b01111110, 8'b00111100, 8'b00011000, 8'b10000001
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_half = 1'b0;
    logic [4:0]  cfg_r_lo = 5'd0, cfg_r_hi = 5'd0;
    logic [5:0]  cfg_g_lo = 6'd0, cfg_g_hi = 6'd0;
    logic [4:0]  cfg_b_lo = 5'd0, cfg_b_hi = 5'd0;
    logic        in_valid = 1'b0;
    logic [15:0] in_pixel = 16'h0;
    logic        in_sof = 1'b0;
    logic        in_eol = 1'b0;
    logic        out_valid, out_edge, out_sof, out_eol;
    logic [8:0]  out_row, out_col;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] pix_mem [NR_MAX][NC_MAX];
    bit          fgm     [NR_MAX][NC_MAX];
    bit m_half;
    int m_rl, m_rh, m_gl, m_gh, m_bl, m_bh;

    always #10 clk = ~clk;

    color_edge_extractor i_color_edge_extractor (
        .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half),
        .cfg_r_lo(cfg_r_lo), .cfg_r_hi(cfg_r_hi),
        .cfg_g_lo(cfg_g_lo), .cfg_g_hi(cfg_g_hi),
        .cfg_b_lo(cfg_b_lo), .cfg_b_hi(cfg_b_hi),
        .in_valid(in_valid), .in_pixel(in_pixel), .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(out_valid), .out_edge(out_edge), .out_row(out_row),
        .out_col(out_col), .out_sof(out_sof), .out_eol(out_eol)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rgb(input int r, input int g, input int b);
        return {r[4:0], g[5:0], b[4:0]};
    endfunction

    // Software model of the keying rules (R1 field layout, R2, R3)
    function automatic bit classify(input logic [15:0] p);
        int r = int'(p[15:11]);
        int g = int'(p[10:5]);
        int b = int'(p[4:0]);
        if (m_half) return !(p[15] || p[10] || p[4]);
        return (r >= m_rl && r <= m_rh && g >= m_gl && g <= m_gh &&
                b >= m_bl && b <= m_bh);
    endfunction

    task automatic set_window();
        cfg_half = 1'b0;
        cfg_r_lo = 5'(R_LO); cfg_r_hi = 5'(R_HI);
        cfg_g_lo = 6'(G_LO); cfg_g_hi = 6'(G_HI);
        cfg_b_lo = 5'(B_LO); cfg_b_hi = 5'(B_HI);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
        @(posedge clk); #1;
        chk(out_valid == 1'b0, "R9 out_valid in gap", int'(out_valid), 0);
        chk(out_edge == 1'b0, "R9 out_edge in gap", int'(out_edge), 0);
    endtask

    task automatic send_pixel(input logic [15:0] p, input bit sof, input bit eol,
                              input bit fg, input bit exp_edge, input int r,
                              input int c, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_pixel = p; in_sof = sof; in_eol = eol;
        @(posedge clk); #1;
        chk(out_valid == 1'b1, "R7 out_valid", int'(out_valid), 1);
        chk(out_edge == exp_edge, fg ? {req, " R6 edge"} : {req, " R5 edge"},
            int'(out_edge), int'(exp_edge));
        chk(out_row == 9'(r) && out_col == 9'(c), "R8 position",
            int'(out_row) * 1000 + int'(out_col), r * 1000 + c);
        chk(out_sof == sof && out_eol == eol, "R7 markers",
            int'({out_sof, out_eol}), int'({sof, eol}));
    endtask

    // Streams pix_mem through the design and checks each output against the model
    task automatic run_frame(input int nr, input int nc, input bit gaps,
                             input bit mid_change, input string req);
        for (int r = 0; r < nr; r++) begin
            for (int c = 0; c < nc; c++) begin
                bit sof = (r == 0 && c == 0);
                bit eol = (c == nc - 1);
                bit fg;
                bit ex;
                if (sof) begin
                    m_half = cfg_half;
                    m_rl = int'(cfg_r_lo); m_rh = int'(cfg_r_hi);
                    m_gl = int'(cfg_g_lo); m_gh = int'(cfg_g_hi);
                    m_bl = int'(cfg_b_lo); m_bh = int'(cfg_b_hi);
                end
                fg = classify(pix_mem[r][c]);
                fgm[r][c] = fg;
                ex = fg && !(r > 0 && c > 0 && fgm[r][c-1] && fgm[r-1][c] && fgm[r-1][c-1]);
                send_pixel(pix_mem[r][c], sof, eol, fg, ex, r, c, req);
                if (sof && mid_change) begin
                    // R4: new settings arrive mid-frame and must be ignored
                    cfg_half = 1'b1;
                    cfg_r_lo = 5'd31; cfg_r_hi = 5'd0;
                end
                if (gaps && (c % 3 == 2)) idle_cycle();
            end
        end
        idle_cycle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Reset state (R10)
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid == 0 && out_edge == 0 && out_sof == 0 && out_eol == 0,
            "R10 reset outputs", int'({out_valid, out_edge, out_sof, out_eol}), 0);
        @(negedge clk); rst_n = 1'b1;
        set_window();

        // Table of blob stimulus, walked by one loop: window mode with boundary colors
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                int k = (r * 8 + c) % 4;
                if (BLOB[r][7 - c]) begin
                    case (k)
                        0: pix_mem[r][c] = rgb(R_LO, G_LO, B_LO);
                        1: pix_mem[r][c] = rgb(R_HI, G_HI, B_HI);
                        2: pix_mem[r][c] = rgb(R_LO, G_HI, B_LO);
                        default: pix_mem[r][c] = rgb(14, 25, 12);
                    endcase
                end else begin
                    case (k)
                        0: pix_mem[r][c] = rgb(R_LO - 1, G_LO, B_LO);
                        1: pix_mem[r][c] = rgb(R_HI, G_HI + 1, B_HI);
                        2: pix_mem[r][c] = rgb(R_LO, G_LO, B_HI + 1);
                        default: pix_mem[r][c] = rgb(14, G_LO - 1, 12);
                    endcase
                end
            end
        end
        run_frame(8, 8, 1'b0, 1'b0, "R1 R2");

        // Random frame with idle gaps (R2, R9)
        for (int r = 0; r < 12; r++)
            for (int c = 0; c < 10; c++)
                pix_mem[r][c] = ($urandom % 3 != 0) ?
                    rgb(R_LO + int'($urandom % 13), G_LO + int'($urandom % 31),
                        B_LO + int'($urandom % 23)) : 16'($urandom);
        run_frame(12, 10, 1'b1, 1'b0, "R2 R9");

        // Half-intensity mode with limits that would reject everything (R3)
        cfg_half = 1'b1; cfg_r_lo = 5'd31; cfg_r_hi = 5'd0;
        for (int r = 0; r < 6; r++)
            for (int c = 0; c < 7; c++)
                pix_mem[r][c] = ($urandom % 2 == 0) ? (16'($urandom) & 16'h7BEF) : 16'($urandom);
        run_frame(6, 7, 1'b0, 1'b0, "R3");

        // Settings change right after the start of frame (R4)
        set_window();
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < 5; c++)
                pix_mem[r][c] = (r > 0 && c > 0) ? rgb(18, 20, 10) : rgb(9, 12, 4);
        run_frame(5, 5, 1'b0, 1'b1, "R4 held");
        // The changed settings take effect on the next frame (R4)
        run_frame(5, 5, 1'b0, 1'b0, "R4 next frame");

        // Full-width two-row frame: column counter reaches 511 (R6, R8)
        set_window();
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < NC_MAX; c++)
                pix_mem[r][c] = rgb(12, 30, 9);
        run_frame(2, NC_MAX, 1'b0, 1'b0, "R6 R8 wide");

        // Reset in the middle of a frame (R10), then a fresh frame
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            in_valid = 1'b1; in_pixel = rgb(12, 30, 9);
            in_sof = (c == 0); in_eol = 1'b0;
        end
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; in_sof = 1'b1; in_eol = 1'b1;
        @(posedge clk); #1;
        chk(out_valid == 0 && out_edge == 0 && out_sof == 0 && out_eol == 0,
            "R10 reset mid-frame", int'({out_valid, out_edge, out_sof, out_eol}), 0);
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 4; c++)
                pix_mem[r][c] = rgb(12, 30, 9);
        run_frame(3, 4, 1'b0, 1'b0, "R10 after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule